// File: doc/BRIEF.md
# Two-Wire Potentiometer Register Access Engine

This block is the byte-level protocol engine of a two-wire bus slave that fronts a bank of four digital potentiometers. A separate bit-level front end turns SCL/SDA activity into single-cycle events: START (a repeated START is the same event), STOP, a received byte, and the master's ACK or NACK after a transmitted byte. The engine answers each received byte with an acknowledge decision. It loads bytes for transmission and keeps the potentiometer (DCP) address pointer.

Writes go to the wiper registers through a write strobe. When the status register's nonvolatile-enable bit is set, data bytes are also collected into a page buffer. On STOP that buffer is handed to nonvolatile storage in a single commit pulse, provided the write-protect pin is high. A busy period of a parameterised length follows the commit. While it runs, the slave acknowledges nothing. Reads take their data from the external bank through a combinational lookup port addressed by the pointer.

Top module: `pot_twi_engine`

## Requirements
- R1: After reset, `busy` is 0, no strobe is active, `rd_dcp` and `rd_page` are 0, and a current-address read first returns the bank byte at page 0, DCP 0.
- R2: A received byte in the slave-address slot is acknowledged (`ack_bit`=1) only when bits 7:4 equal 0101 and bits 3:1 equal `hw_addr`; bit 0 = 1 means read. On a mismatch the byte is answered with `ack_bit`=0, and every later byte up to the next START is answered with 0 and has no effect.
- R3: The address byte is accepted when bits 7:3 are zero and bits 2:0 are 0 to 3 (DCP select) or 7 (status register). Values 4 to 6, or any of bits 7:3 set, are answered with `ack_bit`=0 and the following data bytes are refused.
- R4: With the nonvolatile-enable bit clear, each data byte is acknowledged and produces `wcr_we` with `wcr_dcp` and `wcr_data` one cycle later. A following STOP does not raise `busy`.
- R5: A data byte sent to address 7 sets the status register: page = bits 2:1, nonvolatile enable = bit 0, and bits 7:3 are dropped. It raises no `busy`, the new page shows on `rd_page`, and reading address 7 returns {00000, page, enable}.
- R6: After every data byte the DCP pointer advances, wrapping from 3 to 0, while the page stays fixed. A fifth byte therefore overwrites the location of the first byte.
- R7: With the enable bit set, data bytes also update the wiper registers. On STOP with `wp_hi`=1, `nv_commit` pulses one cycle later, carrying the page, a mask of the DCPs written and their bytes (DCP k in `nv_data` bits 8k+7:8k, unwritten bytes 0). `busy` is high from that same cycle for NV_CYCLES cycles.
- R8: On STOP with `wp_hi`=0 no commit is issued, `busy` stays 0, and the buffered bytes are discarded, so a later commit carries none of them.
- R9: While `busy` is high, received bytes are answered with `ack_bit`=0, START and STOP are ignored, and no write or transmit strobe is produced.
- R10: An accepted read-mode slave address loads `tx_byte` with the byte at the pointer (`tx_load`), and the pointer then advances. Each master ACK loads the next byte with the same 3-to-0 wrap. A master NACK stops further loads until the next START.
- R11: A write-mode address byte followed by a repeated START and a read-mode slave address starts the read at the addressed DCP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_addr | input | 3 | Strapped device address bits |
| wp_hi | input | 1 | Write-protect pin, high allows nonvolatile commit |
| ev_start | input | 1 | START or repeated START seen |
| ev_stop | input | 1 | STOP seen |
| ev_byte | input | 1 | A byte was received |
| rx_byte | input | 8 | Received byte |
| ev_mack | input | 1 | Master acknowledged a transmitted byte |
| ev_mnack | input | 1 | Master did not acknowledge a transmitted byte |
| ack_valid | output | 1 | Acknowledge decision is valid |
| ack_bit | output | 1 | 1 = acknowledge, 0 = release SDA |
| tx_load | output | 1 | New byte for transmission |
| tx_byte | output | 8 | Byte to transmit |
| rd_dcp | output | 2 | Pointer DCP for bank lookup |
| rd_page | output | 2 | Selected page for bank lookup |
| rd_data | input | 8 | Bank byte at rd_page/rd_dcp |
| wcr_we | output | 1 | Wiper register write strobe |
| wcr_dcp | output | 2 | Wiper register index |
| wcr_data | output | 8 | Wiper register data |
| nv_commit | output | 1 | Nonvolatile page commit pulse |
| nv_page | output | 2 | Page being committed |
| nv_mask | output | 4 | DCPs written in the commit |
| nv_data | output | 32 | Committed bytes, DCP k at bits 8k+7:8k |
| busy | output | 1 | Nonvolatile cycle in progress |

## Verification
The assertions take the front end's events as mutually exclusive single-cycle pulses. They assume `ev_mack` and `ev_mnack` arrive only after a transmitted byte, and that `wp_hi` is steady around a STOP. The bench drives one event per pulse with idle cycles between events, so no two events ever share a cycle. It changes `wp_hi` only while the bus is idle. Events during the busy window are sent on purpose, to show that they are refused.

// File: rtl/pot_twi_pkg.sv
package pot_twi_pkg;

    localparam int NDCP    = 4;
    localparam int DW      = 8;
    localparam int DCP_W   = $clog2(NDCP);
    localparam int PAGE_W  = 2;
    localparam logic [3:0] DEV_TYPE = 4'b0101;
    localparam logic [2:0] SR_CODE  = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SLAVE, ST_ADDR, ST_WDATA, ST_TX, ST_HOLD
    } eng_state_e;

    typedef struct packed {
        logic match;
        logic rd;
    } slv_dec_t;

    typedef struct packed {
        logic             ok;
        logic             sr_sel;
        logic [DCP_W-1:0] dcp;
    } adr_dec_t;

    typedef struct packed {
        logic [DW-PAGE_W-2:0] rsvd;
        logic [PAGE_W-1:0]    page;
        logic                 nv_en;
    } stat_t;

    function automatic slv_dec_t decode_slave(input logic [7:0] b, input logic [2:0] hw);
        slv_dec_t r;
        r.match = (b[7:4] == DEV_TYPE) && (b[3:1] == hw);
        r.rd    = b[0];
        return r;
    endfunction

    function automatic adr_dec_t decode_addr(input logic [7:0] b);
        adr_dec_t r;
        r.sr_sel = (b[2:0] == SR_CODE);
        r.ok     = (b[7:3] == 5'd0) && ((32'(b[2:0]) < NDCP) || r.sr_sel);
        r.dcp    = b[DCP_W-1:0];
        return r;
    endfunction

    function automatic logic [DCP_W-1:0] next_dcp(input logic [DCP_W-1:0] d);
        return (32'(d) == NDCP - 1) ? '0 : d + 1'b1;
    endfunction

endpackage

// File: rtl/pot_twi_decode.sv
module pot_twi_decode
    import pot_twi_pkg::*;
(
    input  logic [7:0] byte_i,
    input  logic [2:0] hw_i,
    output slv_dec_t   slv_o,
    output adr_dec_t   adr_o
);
    assign slv_o = decode_slave(byte_i, hw_i);
    assign adr_o = decode_addr(byte_i);
endmodule

// File: rtl/pot_twi_pagebuf.sv
module pot_twi_pagebuf #(
    parameter int NDCP   = 4,
    parameter int DW     = 8,
    parameter int DCP_W  = 2,
    parameter int PAGE_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [DCP_W-1:0]     wr_dcp,
    input  logic [DW-1:0]        wr_data,
    input  logic                 flush,
    input  logic                 commit_ok,
    input  logic [PAGE_W-1:0]    page,
    output logic                 fire,
    output logic                 nv_commit,
    output logic [PAGE_W-1:0]    nv_page,
    output logic [NDCP-1:0]      nv_mask,
    output logic [NDCP*DW-1:0]   nv_data
);
    logic [NDCP-1:0]    held;
    logic [NDCP*DW-1:0] slots;

    assign fire = flush && commit_ok && (held != '0);

    always_ff @(posedge clk) begin
        if (rst || flush) held <= '0;
        else if (wr_en)   held[wr_dcp] <= 1'b1;
    end

    for (genvar g = 0; g < NDCP; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush)
                slots[g*DW +: DW] <= '0;
            else if (wr_en && (32'(wr_dcp) == g))
                slots[g*DW +: DW] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nv_commit <= 1'b0;
            nv_page   <= '0;
            nv_mask   <= '0;
            nv_data   <= '0;
        end else begin
            nv_commit <= fire;
            if (fire) begin
                nv_page <= page;
                nv_mask <= held;
                nv_data <= slots;
            end
        end
    end

    // R7
    mask_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        nv_commit |-> (nv_mask != '0));
endmodule

// File: rtl/pot_twi_busy.sv
module pot_twi_busy #(
    parameter int CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (kick)         cnt <= CW'(CYC);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R7
    kick_busy_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> busy);
endmodule

// File: rtl/pot_twi_engine.sv
module pot_twi_engine
    import pot_twi_pkg::*;
#(
    parameter int NV_CYCLES = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          hw_addr,
    input  logic                wp_hi,
    input  logic                ev_start,
    input  logic                ev_stop,
    input  logic                ev_byte,
    input  logic [7:0]          rx_byte,
    input  logic                ev_mack,
    input  logic                ev_mnack,
    output logic                ack_valid,
    output logic                ack_bit,
    output logic                tx_load,
    output logic [DW-1:0]       tx_byte,
    output logic [DCP_W-1:0]    rd_dcp,
    output logic [PAGE_W-1:0]   rd_page,
    input  logic [DW-1:0]       rd_data,
    output logic                wcr_we,
    output logic [DCP_W-1:0]    wcr_dcp,
    output logic [DW-1:0]       wcr_data,
    output logic                nv_commit,
    output logic [PAGE_W-1:0]   nv_page,
    output logic [NDCP-1:0]     nv_mask,
    output logic [NDCP*DW-1:0]  nv_data,
    output logic                busy
);
    eng_state_e       state;
    stat_t            stat;
    logic [DCP_W-1:0] dcp;
    logic             sr_sel;
    slv_dec_t         sd;
    adr_dec_t         ad;
    logic             buf_wr, flush, fire;
    logic [DW-1:0]    cur_byte;

    pot_twi_decode i_dec (
        .byte_i (rx_byte),
        .hw_i   (hw_addr),
        .slv_o  (sd),
        .adr_o  (ad)
    );

    assign buf_wr   = !busy && ev_byte && !ev_start && !ev_stop
                      && (state == ST_WDATA) && !sr_sel && stat.nv_en;
    assign flush    = !busy && ev_stop && !ev_start;
    assign cur_byte = sr_sel ? DW'(stat) : rd_data;
    assign rd_dcp   = dcp;
    assign rd_page  = stat.page;

    pot_twi_pagebuf #(
        .NDCP(NDCP), .DW(DW), .DCP_W(DCP_W), .PAGE_W(PAGE_W)
    ) i_buf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (buf_wr),
        .wr_dcp    (dcp),
        .wr_data   (rx_byte),
        .flush     (flush),
        .commit_ok (wp_hi),
        .page      (stat.page),
        .fire      (fire),
        .nv_commit (nv_commit),
        .nv_page   (nv_page),
        .nv_mask   (nv_mask),
        .nv_data   (nv_data)
    );

    pot_twi_busy #(.CYC(NV_CYCLES)) i_busy (
        .clk  (clk),
        .rst  (rst),
        .kick (fire),
        .busy (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            stat      <= '0;
            dcp       <= '0;
            sr_sel    <= 1'b0;
            ack_valid <= 1'b0;
            ack_bit   <= 1'b0;
            tx_load   <= 1'b0;
            tx_byte   <= '0;
            wcr_we    <= 1'b0;
            wcr_dcp   <= '0;
            wcr_data  <= '0;
        end else begin
            ack_valid <= 1'b0;
            tx_load   <= 1'b0;
            wcr_we    <= 1'b0;
            if (busy) begin
                if (ev_byte) begin
                    ack_valid <= 1'b1;
                    ack_bit   <= 1'b0;
                end
            end else if (ev_start) begin
                state <= ST_SLAVE;
            end else if (ev_stop) begin
                state <= ST_IDLE;
            end else if (ev_byte) begin
                ack_valid <= 1'b1;
                ack_bit   <= 1'b0;
                case (state)
                    ST_SLAVE: begin
                        if (sd.match) begin
                            ack_bit <= 1'b1;
                            if (sd.rd) begin
                                tx_load <= 1'b1;
                                tx_byte <= cur_byte;
                                if (!sr_sel) dcp <= next_dcp(dcp);
                                state <= ST_TX;
                            end else begin
                                state <= ST_ADDR;
                            end
                        end else begin
                            state <= ST_HOLD;
                        end
                    end
                    ST_ADDR: begin
                        if (ad.ok) begin
                            ack_bit <= 1'b1;
                            sr_sel  <= ad.sr_sel;
                            if (!ad.sr_sel) dcp <= ad.dcp;
                            state   <= ST_WDATA;
                        end else begin
                            state <= ST_HOLD;
                        end
                    end
                    ST_WDATA: begin
                        ack_bit <= 1'b1;
                        if (sr_sel) begin
                            stat.page  <= rx_byte[PAGE_W:1];
                            stat.nv_en <= rx_byte[0];
                        end else begin
                            wcr_we   <= 1'b1;
                            wcr_dcp  <= dcp;
                            wcr_data <= rx_byte;
                            dcp      <= next_dcp(dcp);
                        end
                    end
                    default: ack_bit <= 1'b0;
                endcase
            end else if (ev_mack && state == ST_TX) begin
                tx_load <= 1'b1;
                tx_byte <= cur_byte;
                if (!sr_sel) dcp <= next_dcp(dcp);
            end else if (ev_mnack && state == ST_TX) begin
                state <= ST_HOLD;
            end
        end
    end

    // R9
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !(ack_valid && ack_bit) && !wcr_we && !tx_load);

    // R7
    commit_busy_chk: assert property (@(posedge clk) disable iff (rst)
        nv_commit |-> busy);

    // R8
    commit_wp_chk: assert property (@(posedge clk) disable iff (rst)
        nv_commit |-> $past(wp_hi));

    // R2
    ack_src_chk: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> $past(ev_byte));

    // R10
    tx_src_chk: assert property (@(posedge clk) disable iff (rst)
        tx_load |-> ($past(ev_byte) || $past(ev_mack)));

    // R4
    wcr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        wcr_we |-> $past(ev_byte) && !$past(busy));
endmodule

// File: tb/test_pot_twi_engine.sv
module test_pot_twi_engine;
    localparam int NVC = 20;
    localparam int K_ACK = 0, K_WCR = 1, K_TX = 2, K_NV = 3;

    typedef struct {
        int          kind;
        logic [31:0] a;
        logic [31:0] b;
        string       req;
    } exp_t;

    logic        clk = 0, rst = 1;
    logic [2:0]  hw_addr = 3'b010;
    logic        wp_hi = 1;
    logic        ev_start = 0, ev_stop = 0, ev_byte = 0, ev_mack = 0, ev_mnack = 0;
    logic [7:0]  rx_byte = 0;
    logic        ack_valid, ack_bit, tx_load, wcr_we, nv_commit, busy;
    logic [7:0]  tx_byte, rd_data, wcr_data;
    logic [1:0]  rd_dcp, rd_page, wcr_dcp, nv_page;
    logic [3:0]  nv_mask;
    logic [31:0] nv_data;

    int checks = 0, fails = 0, cyc = 0;
    exp_t sbq[$];

    always #5 clk = ~clk;

    assign rd_data = {2'b01, rd_page, 2'b00, rd_dcp};

    function automatic logic [7:0] bank(input int p, input int d);
        return {2'b01, 2'(p), 2'b00, 2'(d)};
    endfunction

    pot_twi_engine #(.NV_CYCLES(NVC)) i_pot_twi_engine (
        .clk(clk), .rst(rst), .hw_addr(hw_addr), .wp_hi(wp_hi),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte(ev_byte), .rx_byte(rx_byte),
        .ev_mack(ev_mack), .ev_mnack(ev_mnack),
        .ack_valid(ack_valid), .ack_bit(ack_bit), .tx_load(tx_load), .tx_byte(tx_byte),
        .rd_dcp(rd_dcp), .rd_page(rd_page), .rd_data(rd_data),
        .wcr_we(wcr_we), .wcr_dcp(wcr_dcp), .wcr_data(wcr_data),
        .nv_commit(nv_commit), .nv_page(nv_page), .nv_mask(nv_mask), .nv_data(nv_data),
        .busy(busy)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exv);
        end
    endtask

    task automatic expect_item(input int kind, input logic [31:0] a, input logic [31:0] b, input string req);
        exp_t e;
        e.kind = kind; e.a = a; e.b = b; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic observe(input int kind, input logic [31:0] a, input logic [31:0] b);
        exp_t e;
        if (sbq.size() == 0) begin
            chk(0, "unexpected output", {kind[7:0], a[23:0]}, 32'hFFFFFFFF);
        end else begin
            e = sbq.pop_front();
            chk(e.kind == kind && e.a == a && e.b == b, e.req,
                {kind[7:0], a[23:0]} ^ b, {e.kind[7:0], e.a[23:0]} ^ e.b);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (ack_valid) observe(K_ACK, {31'b0, ack_bit}, 0);
            if (wcr_we)    observe(K_WCR, {22'b0, wcr_dcp, wcr_data}, 0);
            if (tx_load)   observe(K_TX, {24'b0, tx_byte}, 0);
            if (nv_commit) observe(K_NV, {26'b0, nv_page, nv_mask}, nv_data);
        end
    end

    task automatic pulse_end;
        @(posedge clk); #1;
        ev_start = 0; ev_stop = 0; ev_byte = 0; ev_mack = 0; ev_mnack = 0;
        @(negedge clk);
    endtask
    task automatic do_start; @(negedge clk); #1; ev_start = 1; pulse_end(); endtask
    task automatic do_stop;  @(negedge clk); #1; ev_stop = 1;  pulse_end(); endtask
    task automatic do_mack;  @(negedge clk); #1; ev_mack = 1;  pulse_end(); endtask
    task automatic do_mnack; @(negedge clk); #1; ev_mnack = 1; pulse_end(); endtask
    task automatic do_byte(input logic [7:0] b);
        @(negedge clk); #1; ev_byte = 1; rx_byte = b; pulse_end();
    endtask

    task automatic byte_ack(input logic [7:0] b, input logic a, input string req);
        expect_item(K_ACK, {31'b0, a}, 0, req);
        do_byte(b);
    endtask

    task automatic wait_free;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    localparam logic [7:0] SW = 8'h54, SR_ = 8'h55;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1 busy", busy, 0);
        chk(rd_dcp == 0 && rd_page == 0, "R1 pointer", {rd_page, rd_dcp}, 0);
        chk(!ack_valid && !wcr_we && !tx_load && !nv_commit, "R1 strobes",
            {ack_valid, wcr_we, tx_load, nv_commit}, 0);
        do_start();
        expect_item(K_ACK, 1, 0, "R1");
        expect_item(K_TX, bank(0, 0), 0, "R1 first read byte");
        do_byte(SR_);
        do_mnack();
        do_mack();           // ignored after NACK (R10)
        do_stop();

        // R2 address mismatch, following byte refused
        do_start();
        byte_ack(8'h56, 0, "R2 mismatch");
        byte_ack(8'h00, 0, "R2 hold");
        do_stop();
        do_start();
        byte_ack(8'h64, 0, "R2 type nibble");
        do_stop();

        // R3 bad address bytes
        do_start();
        byte_ack(SW, 1, "R3 slave");
        byte_ack(8'h05, 0, "R3 unused code");
        byte_ack(8'h12, 0, "R3 data refused");
        do_stop();
        do_start();
        byte_ack(SW, 1, "R3 slave");
        byte_ack(8'h08, 0, "R3 high bit set");
        do_stop();

        // R4 volatile write
        do_start();
        byte_ack(SW, 1, "R4");
        byte_ack(8'h02, 1, "R4");
        expect_item(K_ACK, 1, 0, "R4");
        expect_item(K_WCR, {22'b0, 2'd2, 8'h3A}, 0, "R4 wcr");
        do_byte(8'h3A);
        do_stop();
        chk(busy == 0, "R4 no busy", busy, 0);

        // R5 status register write and read back
        do_start();
        byte_ack(SW, 1, "R5");
        byte_ack(8'h07, 1, "R5");
        byte_ack(8'hFB, 1, "R5 sr data");   // page 1, enable 1, high bits dropped
        do_stop();
        chk(busy == 0, "R5 no busy", busy, 0);
        chk(rd_page == 2'd1, "R5 page", rd_page, 1);
        do_start();
        byte_ack(SW, 1, "R5");
        byte_ack(8'h07, 1, "R5");
        do_start();
        expect_item(K_ACK, 1, 0, "R5");
        expect_item(K_TX, 8'h03, 0, "R5 sr read");
        do_byte(SR_);
        do_mnack();
        do_stop();

        // R6/R7 page write with wrap and commit
        do_start();
        byte_ack(SW, 1, "R7");
        byte_ack(8'h02, 1, "R7");
        expect_item(K_ACK, 1, 0, "R6"); expect_item(K_WCR, {22'b0, 2'd2, 8'h11}, 0, "R6");
        do_byte(8'h11);
        expect_item(K_ACK, 1, 0, "R6"); expect_item(K_WCR, {22'b0, 2'd3, 8'h22}, 0, "R6");
        do_byte(8'h22);
        expect_item(K_ACK, 1, 0, "R6"); expect_item(K_WCR, {22'b0, 2'd0, 8'h33}, 0, "R6 wrap");
        do_byte(8'h33);
        expect_item(K_NV, {26'b0, 2'd1, 4'b1101}, 32'h2211_0033, "R7 commit");
        do_stop();
        chk(busy == 1, "R7 busy", busy, 1);
        // R9 events during busy
        do_start();
        byte_ack(SW, 0, "R9 busy nack");
        byte_ack(8'h01, 0, "R9 busy nack");
        do_stop();
        chk(busy == 1, "R9 still busy", busy, 1);
        repeat (NVC) @(negedge clk);
        chk(busy == 0, "R7 busy length", busy, 0);
        // R10 current read continues at DCP1, wraps
        do_start();
        expect_item(K_ACK, 1, 0, "R10");
        expect_item(K_TX, bank(1, 1), 0, "R10");
        do_byte(SR_);
        expect_item(K_TX, bank(1, 2), 0, "R10"); do_mack();
        expect_item(K_TX, bank(1, 3), 0, "R10"); do_mack();
        expect_item(K_TX, bank(1, 0), 0, "R10 wrap"); do_mack();
        do_mnack();
        do_mack();
        do_stop();

        // R6 overwrite on fifth byte
        do_start();
        byte_ack(SW, 1, "R6");
        byte_ack(8'h00, 1, "R6");
        for (int i = 0; i < 5; i++) begin
            expect_item(K_ACK, 1, 0, "R6");
            expect_item(K_WCR, {22'b0, 2'(i % 4), 8'hA0 + 8'(i)}, 0, "R6");
            do_byte(8'hA0 + 8'(i));
        end
        expect_item(K_NV, {26'b0, 2'd1, 4'b1111}, 32'hA3A2_A1A4, "R6 overwrite");
        do_stop();
        wait_free();

        // R8 write protect low discards
        wp_hi = 0;
        do_start();
        byte_ack(SW, 1, "R8");
        byte_ack(8'h01, 1, "R8");
        expect_item(K_ACK, 1, 0, "R8"); expect_item(K_WCR, {22'b0, 2'd1, 8'h55}, 0, "R8");
        do_byte(8'h55);
        do_stop();
        chk(busy == 0, "R8 no busy", busy, 0);
        wp_hi = 1;
        do_start();
        byte_ack(SW, 1, "R8");
        byte_ack(8'h03, 1, "R8");
        expect_item(K_ACK, 1, 0, "R8"); expect_item(K_WCR, {22'b0, 2'd3, 8'h77}, 0, "R8");
        do_byte(8'h77);
        expect_item(K_NV, {26'b0, 2'd1, 4'b1000}, 32'h7700_0000, "R8 discarded");
        do_stop();
        wait_free();

        // R11 random read
        do_start();
        byte_ack(SW, 1, "R11");
        byte_ack(8'h02, 1, "R11");
        do_start();
        expect_item(K_ACK, 1, 0, "R11");
        expect_item(K_TX, bank(1, 2), 0, "R11 random");
        do_byte(SR_);
        do_mnack();
        do_stop();

        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "scoreboard drained", sbq.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule